// File: doc/BRIEF.md
# Read Burst Output Sequencer with Truncation

This block produces the output timing for a double-data-rate read burst. A read command starts a burst of `BL` data words, carried as two beats per clock (one on each clock edge). The block reports which word of the burst sits on each edge, when data is valid, when the data pins are driven, and when the strobe is enabled. The first pair of beats appears `CL` clocks after the read command.

A precharge to the same bank during the burst cuts it short. Beat pairs keep flowing until the clock that starts `CL` clocks after the precharge, and from then on the pins are released. A precharge that comes late enough to miss every remaining pair leaves the burst intact. A new read restarts the sequence from its own starting column. The block has no data storage and no analog strobe timing. A controller drives it with one command per clock.

Top module: `rd_burst_seq`

## Requirements
- R1: While reset is asserted, and until the first read, `dq_valid`, `dq_oe`, `dqs_en`, `beat_rise` and `beat_fall` are all zero.
- R2: A read in clock t makes `dq_valid` high in clock t+CL. In that clock `beat_rise` equals the read column and `beat_fall` equals column+1 modulo BL. Both index outputs are zero in any clock without valid data.
- R3: An uninterrupted read keeps `dq_valid` high for BL/2 consecutive clocks. Each clock, `beat_rise` advances by 2 modulo BL, and `beat_fall` is always `beat_rise`+1 modulo BL.
- R4: A precharge in clock p, with t < p < t+BL/2, makes clock p+CL-1 the last one with valid data. From clock p+CL on, `dq_valid` is low.
- R5: A precharge in clock p ≥ t+BL/2 does not change the burst.
- R6: `dq_oe` is high exactly in the clocks where `dq_valid` is high. The data pins are high-impedance in all other clocks.
- R7: `dqs_en` is high in the clock before the first valid clock of a run of valid data (the preamble) and in every valid clock. It is low in all other clocks.
- R8: A read while a burst is still issuing restarts the sequence. Beat pairs already committed are still delivered. After them, the new read's pairs start at its own column, CL clocks after it.
- R9: If a read and a precharge arrive in the same clock, the read wins and the precharge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command, one clock wide |
| pre_cmd | input | 1 | Precharge of the bank being read, one clock wide |
| rd_col | input | $clog2(BL) | Starting column of the burst, within the burst |
| dq_valid | output | 1 | Beat pair valid this clock |
| dq_oe | output | 1 | Data pin output enable; low means high-impedance |
| dqs_en | output | 1 | Strobe enable window, including preamble |
| beat_rise | output | $clog2(BL) | Word index on the rising-edge beat |
| beat_fall | output | $clog2(BL) | Word index on the falling-edge beat |

## Verification
The bound checker checks the following on every clock:
- the first pair appears CL clocks after a read;
- a precharge without a read in the same clock leaves no data CL clocks later;
- the strobe window covers each valid clock and opens one clock early;
- the index steps by two within a run.

Run lengths, the exact index values, the late-precharge case and the mixed command streams can only be shown by the bench. The bench compares every clock against a schedule that it derives from the read and precharge times.

// File: rtl/rd_burst_seq.sv
module rd_burst_seq #(
  parameter int BL = 8,
  parameter int CL = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_cmd,
  input  logic                  pre_cmd,
  input  logic [$clog2(BL)-1:0] rd_col,
  output logic                  dq_valid,
  output logic                  dq_oe,
  output logic                  dqs_en,
  output logic [$clog2(BL)-1:0] beat_rise,
  output logic [$clog2(BL)-1:0] beat_fall
);
  localparam int IDXW  = $clog2(BL);
  localparam int PAIRS = BL / 2;

  logic            active;
  logic [IDXW-1:0] sent;
  logic [IDXW-1:0] next_idx;

  wire             issue     = rd_cmd | (active & ~pre_cmd);
  wire [IDXW-1:0]  issue_idx = rd_cmd ? rd_col : next_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sent     <= '0;
      next_idx <= '0;
    end else if (rd_cmd) begin
      active   <= (PAIRS > 1);
      sent     <= IDXW'(1);
      next_idx <= rd_col + IDXW'(2);
    end else if (active) begin
      if (pre_cmd) begin
        active <= 1'b0;
      end else begin
        next_idx <= next_idx + IDXW'(2);
        sent     <= sent + IDXW'(1);
        if (sent == IDXW'(PAIRS - 1)) active <= 1'b0;
      end
    end
  end

  logic [CL-1:0]   pv;
  logic [IDXW-1:0] pidx [CL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < CL; i++) pidx[i] <= '0;
    end else begin
      pv[0]   <= issue;
      pidx[0] <= issue_idx;
      for (int i = 1; i < CL; i++) begin
        pv[i]   <= pv[i-1];
        pidx[i] <= pidx[i-1];
      end
    end
  end

  assign dq_valid  = pv[CL-1];
  assign dq_oe     = pv[CL-1];
  assign dqs_en    = pv[CL-1] | pv[CL-2];
  assign beat_rise = pv[CL-1] ? pidx[CL-1] : '0;
  assign beat_fall = pv[CL-1] ? pidx[CL-1] + IDXW'(1) : '0;

endmodule

// File: rtl/rd_burst_seq_chk.sv
module rd_burst_seq_chk #(
  parameter int BL = 8,
  parameter int CL = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_cmd,
  input logic                  pre_cmd,
  input logic                  dq_valid,
  input logic                  dqs_en,
  input logic [$clog2(BL)-1:0] beat_rise
);
  localparam int IDXW = $clog2(BL);

  logic [CL-1:0] rd_d, cut_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d  <= '0;
      cut_d <= '0;
    end else begin
      rd_d  <= {rd_d[CL-2:0], rd_cmd};
      cut_d <= {cut_d[CL-2:0], pre_cmd & ~rd_cmd};
    end
  end

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d[CL-1] |-> dq_valid);

  // R4
  cut_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut_d[CL-1] |-> !dq_valid);

  // R7
  strobe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dqs_en);

  // R7
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dqs_en));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && $past(dq_valid) && !rd_d[CL-1]) |->
      beat_rise == IDXW'($past(beat_rise) + IDXW'(2)));

endmodule

bind rd_burst_seq rd_burst_seq_chk #(.BL(BL), .CL(CL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .pre_cmd(pre_cmd),
  .dq_valid(dq_valid), .dqs_en(dqs_en), .beat_rise(beat_rise)
);

// File: tb/rd_burst_seq_tb.sv
module rd_burst_seq_tb;
  localparam int BL = 8;
  localparam int CL = 3;
  localparam int IDXW = $clog2(BL);
  localparam int PAIRS = BL / 2;
  localparam int DEPTH = 1024;

  logic clk = 0, rst_n = 0, rd_cmd = 0, pre_cmd = 0;
  logic [IDXW-1:0] rd_col = '0;
  logic dq_valid, dq_oe, dqs_en;
  logic [IDXW-1:0] beat_rise, beat_fall;

  rd_burst_seq #(.BL(BL), .CL(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .pre_cmd(pre_cmd),
    .rd_col(rd_col), .dq_valid(dq_valid), .dq_oe(dq_oe), .dqs_en(dqs_en),
    .beat_rise(beat_rise), .beat_fall(beat_fall)
  );

  always #2ns clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit exp_v [DEPTH];
  int exp_i [DEPTH];
  bit m_act = 0;
  int m_k = 0, m_col = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  function automatic int fall_of(int r);
    return (r + 1) % BL;
  endfunction

  task automatic step(bit rd, bit pre, int col, string tag);
    int ev, ei;
    @(negedge clk);
    ev = exp_v[cyc % DEPTH];
    ei = ev ? exp_i[cyc % DEPTH] : 0;
    chk(dq_valid == ev, tag, dq_valid, ev);
    chk(dq_oe == ev, "R6", dq_oe, ev);
    chk(dqs_en == (ev | exp_v[(cyc + 1) % DEPTH]), "R7", dqs_en,
        ev | exp_v[(cyc + 1) % DEPTH]);
    chk(beat_rise == ei, ev ? "R3" : "R2", beat_rise, ei);
    chk(beat_fall == (ev ? fall_of(ei) : 0), "R3", beat_fall, ev ? fall_of(ei) : 0);
    exp_v[(cyc + CL) % DEPTH] = 0;
    if (rd) begin
      exp_v[(cyc + CL) % DEPTH] = 1;
      exp_i[(cyc + CL) % DEPTH] = col;
      m_col = col; m_k = 1; m_act = (PAIRS > 1);
    end else if (m_act && !pre) begin
      exp_v[(cyc + CL) % DEPTH] = 1;
      exp_i[(cyc + CL) % DEPTH] = (m_col + 2 * m_k) % BL;
      m_k++;
      if (m_k == PAIRS) m_act = 0;
    end else if (pre) begin
      m_act = 0;
    end
    rd_cmd = rd; pre_cmd = pre; rd_col = IDXW'(col);
    exp_v[(cyc + CL + 1) % DEPTH] = 0;
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    #(4ns * 200000);
    failures++;
    $display("FAIL watchdog cycle=%0d actual=0 expected=1", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) begin exp_v[i] = 0; exp_i[i] = 0; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dq_valid == 0 && dq_oe == 0 && dqs_en == 0, "R1", dq_valid | dq_oe | dqs_en, 0);
      chk(beat_rise == 0 && beat_fall == 0, "R1", beat_rise + beat_fall, 0);
    end
    rst_n = 1;
    idle(2, "R1");
    // plain burst, column 0
    step(1, 0, 0, "R2"); idle(8, "R2");
    // wrapping start column
    step(1, 0, 5, "R3"); idle(8, "R3");
    // earliest precharge: one pair only
    step(1, 0, 2, "R4"); step(0, 1, 0, "R4"); idle(6, "R4");
    // mid-burst precharge
    step(1, 0, 1, "R4"); idle(1, "R4"); step(0, 1, 0, "R4"); idle(6, "R4");
    // precharge at the non-truncating point and later
    step(1, 0, 3, "R5"); idle(3, "R5"); step(0, 1, 0, "R5"); idle(6, "R5");
    step(1, 0, 6, "R5"); idle(5, "R5"); step(0, 1, 0, "R5"); idle(6, "R5");
    // restart during a burst
    step(1, 0, 0, "R8"); idle(1, "R8"); step(1, 0, 4, "R8"); idle(8, "R8");
    // back-to-back reads
    step(1, 0, 7, "R8"); step(1, 0, 1, "R8"); idle(8, "R8");
    // read and precharge together
    step(1, 1, 2, "R9"); idle(8, "R9");
    step(1, 0, 0, "R9"); step(1, 1, 3, "R9"); idle(8, "R9");
    // random mix
    for (int i = 0; i < 500; i++) begin
      bit r, p;
      r = ($urandom % 8) == 0;
      p = ($urandom % 6) == 0;
      step(r, p, int'($urandom % BL), "R8");
    end
    idle(10, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule